// File: doc/BRIEF.md
# Serial Receive Deframer with Sync Search

The block takes a recovered serial bit stream, one bit per bit-period strobe, and turns it into bytes. A shift register of the most recent 16 bits is compared on every strobe against three programmable synchronization words. Each word can be enabled on its own. A match on any enabled word means that valid data starts with the next bit. The match sets that word's own status flag, restarts the byte phase counter so that the next byte boundary falls 8 bits after the end of the word, and presets a running CRC-16.

A byte counter runs freely, so a byte-ready event fires every 8 strobes whether or not framed data is arriving. On each byte event the last 8 bits, taken MSB first, are latched into a data register and the byte-ready flag is set. When the CRC over the bytes since sync, including the two transmitted check bytes, leaves the expected residue at a byte event, a checksum-good flag is also set. Software reads status or data through a small read port. A status read clears every flag. An active-low interrupt is asserted while any flag whose mask bit is set is active.

Top module: `rx_deframer`

## Requirements
- R1: On each bit strobe the new bit shifts into a 16-bit window. When the updated window equals sync word k and enable bit k is 1, status bit k (k = 0, 1, 2) is set.
- R2: A sync word whose enable bit is 0 never sets its status bit, even when its exact pattern is received.
- R3: A sync match restarts the byte phase. No byte-ready event occurs on the first 7 strobes after the matching strobe, and one occurs on the 8th.
- R4: Without sync, a byte-ready event occurs on every 8th strobe after reset. It sets status bit 3 and loads the last 8 bits received, first bit in the MSB, into the data register (read address 1).
- R5: The data register keeps its value until the next byte-ready event.
- R6: A sync match presets the CRC (polynomial 0x1021, preset 0xFFFF, MSB first) over the following bits. At a byte event where the CRC over all bytes since sync, with the check value appended high byte first, equals 0x0000, status bit 4 is set together with bit 3, and the data register holds the low check byte. A corrupted check value does not set bit 4.
- R7: Reading address 0 returns the flags in bits 4:0, with zeros above. The read clears all flags at the clock edge where rd_en_i is high. Reading address 1 clears nothing.
- R8: irq_no is low exactly when some flag is set whose bit in irq_mask_i is 1.
- R9: If a status read and a flag-setting event fall in the same clock cycle, the new flag is set after that edge.
- R10: After reset all flags are 0, the data register is 0 and irq_no is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Recovered data bit |
| bit_stb_i | input | 1 | One-cycle strobe, bit_i valid |
| sync_word_i | input | 3x16 | Sync patterns, index k for word k |
| sync_en_i | input | 3 | Per-word match enable |
| irq_mask_i | input | 5 | Interrupt enable per status bit |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 1 | 0 = status, 1 = data |
| rd_data_o | output | 8 | Read data |
| irq_no | output | 1 | Interrupt, active low |

## Verification
A status read that clears the flags can land in the same clock cycle as the bit strobe that completes a byte. The bench drives rd_en_i and bit_stb_i together on the eighth bit of a byte. A following status read must then show the byte-ready bit set, which proves that the new event survives the clear. A sync match that coincides with a free-running byte boundary is exercised as well: the bench sends a sync word out of phase with the byte counter and checks where the next byte event falls.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic {
    ADDR_STATUS = 1'b0,
    ADDR_DATA   = 1'b1
  } rxd_addr_e;

  localparam logic [15:0] CRC_POLY_DEF    = 16'h1021;
  localparam logic [15:0] CRC_INIT_DEF    = 16'hFFFF;
  localparam logic [15:0] CRC_RESIDUE_DEF = 16'h0000;
endpackage

// File: rtl/rxd_sync_corr.sv
module rxd_sync_corr #(
  parameter int SYNC_W   = 16,
  parameter int NUM_SYNC = 3,
  parameter int BYTE_W   = 8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              bit_i,
  input  logic                              stb_i,
  input  logic [NUM_SYNC-1:0][SYNC_W-1:0]   sync_word_i,
  input  logic [NUM_SYNC-1:0]               sync_en_i,
  output logic [NUM_SYNC-1:0]               hit_o,
  output logic [BYTE_W-1:0]                 byte_o
);
  logic [SYNC_W-1:0] win_q, win_next;

  assign win_next = {win_q[SYNC_W-2:0], bit_i};
  assign byte_o   = win_next[BYTE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    win_q <= '0;
    else if (stb_i) win_q <= win_next;
  end

  for (genvar k = 0; k < NUM_SYNC; k++) begin : g_cmp
    assign hit_o[k] = stb_i && sync_en_i[k] && (win_next == sync_word_i[k]);
  end
endmodule

// File: rtl/rxd_crc.sv
module rxd_crc #(
  parameter int               CRC_W   = 16,
  parameter logic [CRC_W-1:0] POLY    = rxd_pkg::CRC_POLY_DEF,
  parameter logic [CRC_W-1:0] INIT    = rxd_pkg::CRC_INIT_DEF,
  parameter logic [CRC_W-1:0] RESIDUE = rxd_pkg::CRC_RESIDUE_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic upd_i,
  input  logic bit_i,
  output logic good_o
);
  logic [CRC_W-1:0] crc_q, crc_next;
  logic             fb;

  assign fb       = crc_q[CRC_W-1] ^ bit_i;
  assign crc_next = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  // residue as it will stand after the current bit
  assign good_o   = (crc_next == RESIDUE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= INIT;
    else if (clr_i) crc_q <= INIT;
    else if (upd_i) crc_q <= crc_next;
  end
endmodule

// File: rtl/rxd_status.sv
module rxd_status #(
  parameter int NUM_FLAGS = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_FLAGS-1:0] set_i,
  input  logic                 clr_i,
  input  logic [NUM_FLAGS-1:0] mask_i,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic                 irq_no
);
  logic [NUM_FLAGS-1:0] flags_q;

  // a set in the clearing cycle wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (clr_i ? '0 : flags_q) | set_i;
  end

  assign flags_o = flags_q;
  assign irq_no  = ~|(flags_q & mask_i);
endmodule

// File: rtl/rx_deframer.sv
module rx_deframer #(
  parameter int SYNC_W   = 16,
  parameter int NUM_SYNC = 3,
  parameter int BYTE_W   = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             bit_i,
  input  logic                             bit_stb_i,
  input  logic [NUM_SYNC-1:0][SYNC_W-1:0]  sync_word_i,
  input  logic [NUM_SYNC-1:0]              sync_en_i,
  input  logic [NUM_SYNC+1:0]              irq_mask_i,
  input  logic                             rd_en_i,
  input  logic                             rd_addr_i,
  output logic [BYTE_W-1:0]                rd_data_o,
  output logic                             irq_no
);
  localparam int NUM_FLAGS = NUM_SYNC + 2;
  localparam int FLG_BYTE  = NUM_SYNC;
  localparam int FLG_CRC   = NUM_SYNC + 1;
  localparam int CNT_W     = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

  logic [NUM_SYNC-1:0]  sync_hit;
  logic                 sync_any;
  logic [BYTE_W-1:0]    win_byte;
  logic [BYTE_W-1:0]    data_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 byte_evt;
  logic                 crc_good;
  logic                 rd_clr;
  logic [NUM_FLAGS-1:0] flag_set;
  logic [NUM_FLAGS-1:0] flags_q;

  rxd_sync_corr #(
    .SYNC_W  (SYNC_W),
    .NUM_SYNC(NUM_SYNC),
    .BYTE_W  (BYTE_W)
  ) i_corr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_i      (bit_i),
    .stb_i      (bit_stb_i),
    .sync_word_i(sync_word_i),
    .sync_en_i  (sync_en_i),
    .hit_o      (sync_hit),
    .byte_o     (win_byte)
  );

  assign sync_any = |sync_hit;
  assign byte_evt = bit_stb_i && !sync_any && (cnt_q == CNT_W'(BYTE_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      data_q <= '0;
    end else if (bit_stb_i) begin
      if (sync_any || byte_evt) cnt_q <= '0;
      else                      cnt_q <= cnt_q + 1'b1;
      if (byte_evt)             data_q <= win_byte;
    end
  end

  rxd_crc #(
    .CRC_W(16)
  ) i_crc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (sync_any),
    .upd_i (bit_stb_i),
    .bit_i (bit_i),
    .good_o(crc_good)
  );

  assign rd_clr = rd_en_i && (rd_addr_i == rxd_pkg::ADDR_STATUS);

  always_comb begin
    flag_set                = '0;
    flag_set[NUM_SYNC-1:0]  = sync_hit;
    flag_set[FLG_BYTE]      = byte_evt;
    flag_set[FLG_CRC]       = byte_evt && crc_good;
  end

  rxd_status #(
    .NUM_FLAGS(NUM_FLAGS)
  ) i_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (flag_set),
    .clr_i  (rd_clr),
    .mask_i (irq_mask_i),
    .flags_o(flags_q),
    .irq_no (irq_no)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == rxd_pkg::ADDR_DATA) rd_data_o = data_q;
    else                                 rd_data_o[NUM_FLAGS-1:0] = flags_q;
  end
endmodule

// File: rtl/rxd_deframer_chk.sv
module rxd_deframer_chk #(
  parameter int NUM_SYNC = 3,
  parameter int BYTE_W   = 8,
  parameter int CNT_W    = 3
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  bit_stb_i,
  input logic                  rd_en_i,
  input logic                  rd_addr_i,
  input logic                  sync_any,
  input logic                  byte_evt,
  input logic                  crc_good,
  input logic [CNT_W-1:0]      cnt_q,
  input logic [BYTE_W-1:0]     data_q,
  input logic [NUM_SYNC+1:0]   flags_q
);
  AST_SYNC_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_any |=> (flags_q[NUM_SYNC-1:0] != '0)); // R1
  AST_SYNC_REPHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_any |=> (cnt_q == '0)); // R3
  AST_BYTE_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_evt |=> flags_q[NUM_SYNC]); // R4
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_evt |=> $stable(data_q)); // R5
  AST_CRC_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_evt && crc_good) |=> (flags_q[NUM_SYNC+1] && flags_q[NUM_SYNC])); // R6
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rd_addr_i && !bit_stb_i) |=> (flags_q == '0)); // R7
  AST_CLEAR_KEEPS_NEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rd_addr_i && byte_evt) |=> flags_q[NUM_SYNC]); // R9
endmodule

bind rx_deframer rxd_deframer_chk #(
  .NUM_SYNC(NUM_SYNC),
  .BYTE_W  (BYTE_W),
  .CNT_W   (CNT_W)
) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .bit_stb_i(bit_stb_i),
  .rd_en_i  (rd_en_i),
  .rd_addr_i(rd_addr_i),
  .sync_any (sync_any),
  .byte_evt (byte_evt),
  .crc_good (crc_good),
  .cnt_q    (cnt_q),
  .data_q   (data_q),
  .flags_q  (flags_q)
);

// File: tb/test_rx_deframer.sv
module test_rx_deframer;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] SW0 = 16'h3C5A;
  localparam logic [15:0] SW1 = 16'hE4B2;
  localparam logic [15:0] SW2 = 16'h7D21;
  // {data byte, expected status after it}
  localparam logic [15:0] VEC [4] = '{16'h01_08, 16'h7E_08, 16'hF0_08, 16'h35_08};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bit_in = 1'b0;
  logic             stb = 1'b0;
  logic [2:0][15:0] sync_word;
  logic [2:0]       sync_en = 3'b000;
  logic [4:0]       irq_mask = 5'h1F;
  logic             rd_en = 1'b0;
  logic             rd_addr = 1'b0;
  logic [7:0]       rd_data;
  logic             irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  assign sync_word[0] = SW0;
  assign sync_word[1] = SW1;
  assign sync_word[2] = SW2;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_deframer i_rx_deframer (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .bit_i      (bit_in),
    .bit_stb_i  (stb),
    .sync_word_i(sync_word),
    .sync_en_i  (sync_en),
    .irq_mask_i (irq_mask),
    .rd_en_i    (rd_en),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data),
    .irq_no     (irq_n)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_in = b;
    stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
  endtask

  task automatic send_bits(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1;
    rd_addr = a;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic f = r[15] ^ b[i];
      r = {r[14:0], 1'b0};
      if (f) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic framed(input logic corrupt);
    logic [7:0]  v;
    logic [15:0] c = 16'hFFFF;
    sync_en = 3'b001;
    send_bits(SW0, 16);
    rd(1'b0, v);
    chk("R1 sync0 flag", 16'(v[2:0]), 16'h1);
    for (int i = 0; i < 4; i++) begin
      send_bits(16'(VEC[i][15:8]), 8);
      c = crc_byte(c, VEC[i][15:8]);
      rd(1'b0, v);
      chk("R4 table status", 16'(v), 16'(VEC[i][7:0]));
      rd(1'b1, v);
      chk("R4 table data", 16'(v), 16'(VEC[i][15:8]));
    end
    if (corrupt) c = c ^ 16'h0001;
    send_bits(16'(c[15:8]), 8);
    rd(1'b0, v);
    chk("R6 crc high byte status", 16'(v), 16'h08);
    send_bits(16'(c[7:0]), 8);
    rd(1'b0, v);
    chk("R6 crc low byte status", 16'(v), corrupt ? 16'h08 : 16'h18);
    rd(1'b1, v);
    chk("R6 crc low byte in data", 16'(v), 16'(c[7:0]));
    sync_en = 3'b000;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    #1 chk("R10 irq idle", 16'(irq_n), 16'h1);
    rd(1'b0, v); chk("R10 status zero", 16'(v), 16'h0);
    rd(1'b1, v); chk("R10 data zero", 16'(v), 16'h0);

    // R4 free-running byte, MSB first
    send_bits(16'h00C3, 8);
    rd(1'b1, v); chk("R4 free byte data", 16'(v), 16'hC3);
    rd(1'b0, v); chk("R4 free byte status", 16'(v), 16'h08);
    rd(1'b0, v); chk("R7 status cleared", 16'(v), 16'h0);

    // R2 disabled word ignored
    send_bits(SW0, 16);
    rd(1'b0, v); chk("R2 disabled sync", 16'(v[2:0]), 16'h0);

    // R3 sync out of byte phase
    sync_en = 3'b111;
    send_bits(16'h0000, 3);
    send_bits(SW1, 16);
    rd(1'b0, v); chk("R1 sync1 flag", 16'(v[2:0]), 16'h2);
    send_bits(16'h0055, 7);
    rd(1'b0, v); chk("R3 no byte before 8 bits", 16'(v), 16'h0);
    send_bit(1'b0);
    rd(1'b0, v); chk("R3 byte at 8th bit", 16'(v), 16'h08);
    rd(1'b1, v); chk("R3 realigned data", 16'(v), 16'hAA);

    // R5 hold
    send_bits(16'h0005, 3);
    rd(1'b1, v); chk("R5 data held", 16'(v), 16'hAA);
    send_bits(16'h0000, 5);
    sync_en = 3'b100;
    send_bits(SW2, 16);
    rd(1'b0, v); chk("R1 sync2 flag", 16'(v[2:0]), 16'h4);
    sync_en = 3'b000;

    // table walk + check bytes
    framed(1'b0);
    framed(1'b1);

    // R8 interrupt mask
    rd(1'b0, v);
    irq_mask = 5'h10;
    send_bits(16'h0012, 8);
    #1 chk("R8 masked flag no irq", 16'(irq_n), 16'h1);
    irq_mask = 5'h08;
    #1 chk("R8 unmasked flag irq", 16'(irq_n), 16'h0);
    rd(1'b1, v);
    #1 chk("R7 data read keeps irq", 16'(irq_n), 16'h0);
    rd(1'b0, v);
    #1 chk("R8 irq released after read", 16'(irq_n), 16'h1);

    // R9 read and byte event in the same cycle
    send_bits(16'h0000, 7);
    @(negedge clk);
    bit_in = 1'b1;
    stb = 1'b1;
    rd_en = 1'b1;
    rd_addr = 1'b0;
    @(negedge clk);
    stb = 1'b0;
    rd_en = 1'b0;
    rd(1'b0, v); chk("R9 new flag kept", 16'(v), 16'h08);
    rd(1'b1, v); chk("R9 data of that byte", 16'(v), 16'h01);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule